// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one channel of a general-purpose timer with the channel set up as an output. Each cycle it compares the timer count against an active compare value. The comparison result, the configured mode and a few event inputs together set a single-bit reference waveform. From that waveform the block derives a main output and a complementary output, and each of the two has its own polarity bit. The counter and the update event are generated outside the block.

Software sets up the channel through a small write-only port. A configuration word holds the channel direction, the mode, the preload enable, the fast-trigger enable and the clear enable. A compare word holds the compare value. An output word holds the channel enable and the two polarity bits. The compare value can be taken at once or held in a shadow register until the next update event. When a lock level of 3 is applied, the mode and preload bits of an output channel cannot be changed.

Top module: `tim_oc_channel`

## Requirements
- R1: After reset every register is 0. The reference is low, the channel is disabled and both outputs sit at 0.
- R2: Register writes take effect at the clock edge where `wr_en` is high. Address 0 is configuration: bits [1:0] direction, bit 2 fast enable, bit 3 preload enable, bits [7:4] mode, bit 8 clear enable. Address 1 is the compare value. Address 2 is output control: bit 0 enable, bit 1 main polarity, bit 2 complementary polarity.
- R3: Mode 6 drives the reference high while count < compare and low otherwise. Mode 7 is the inverse. In both cases the reference is registered and follows one clock edge after the inputs.
- R4: In modes 6 and 7 the reference is reloaded from the comparison only when the comparison result changes or when the mode code changes. After a clear it stays low until the comparison next changes.
- R5: Modes 1, 2 and 3 act once for each new equality of count and compare value. Mode 1 sets the reference, mode 2 clears it and mode 3 toggles it. A count that stays at the compare value acts only once.
- R6: Mode 4 forces the reference low and mode 5 forces it high. Mode 0 and the reserved codes 8 to 15 hold the reference unchanged.
- R7: With preload off, a compare write takes effect at its write edge. With preload on, writes go to a shadow register, and `upd` copies the shadow into the active value.
- R8: With clear enable set, a high `clr_in` forces the `oc_ref` port low in the same cycle and clears the stored reference. With clear enable off, `clr_in` is ignored.
- R9: With fast enable set in mode 6 or 7, a rising edge on `trig` drives the reference to its match level (0 in mode 6, 1 in mode 7) at the third rising clock edge that samples `trig` high. In every other case `trig` has no direct effect on the reference.
- R10: The direction field can be written only while the channel is disabled. The outputs are active only when the channel is enabled and the direction is 00.
- R11: When `lock_lvl` is 3 and the direction is 00, writes to the mode and preload bits are ignored. The other configuration bits can still be written.
- R12: When active, `oc_out` = reference XOR main polarity and `oc_n` = NOT reference XOR complementary polarity. When inactive, each output sits at its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | CNT_W | Timer counter value |
| upd | input | 1 | Update event pulse |
| trig | input | 1 | Trigger input |
| clr_in | input | 1 | External reference clear |
| lock_lvl | input | 2 | Configuration lock level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| oc_ref | output | 1 | Reference waveform, active high |
| oc_out | output | 1 | Main output after polarity |
| oc_n | output | 1 | Complementary output after polarity |

## Verification
The hardest state to reach from the ports is a PWM reference that has been pushed away from what the comparison says, by a clear or by a fast trigger, and must then stay there while the count keeps the comparison result unchanged. The bench gets there by holding the count on one side of the compare value, firing the clear or the trigger, and then stepping the count without crossing the compare value before it finally crosses. Complete count-by-compare sweeps in both PWM modes, and repeated count sweeps in the match modes, cover the ordinary behaviour arithmetically.

// File: rtl/tim_oc_channel.sv
module tim_oc_channel #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              upd,
  input  logic              trig,
  input  logic              clr_in,
  input  logic [1:0]        lock_lvl,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              oc_ref,
  output logic              oc_out,
  output logic              oc_n
);

  localparam logic [3:0] M_SET  = 4'd1;
  localparam logic [3:0] M_CLR  = 4'd2;
  localparam logic [3:0] M_TGL  = 4'd3;
  localparam logic [3:0] M_LOW  = 4'd4;
  localparam logic [3:0] M_HIGH = 4'd5;
  localparam logic [3:0] M_PWM1 = 4'd6;
  localparam logic [3:0] M_PWM2 = 4'd7;

  logic [1:0]       dir_r;
  logic             fast_r, pre_r, clre_r;
  logic [3:0]       mode_r, mode_q;
  logic [CNT_W-1:0] ccr_sh, ccr_act;
  logic             en_r, polm_r, poln_r;
  logic             ref_q, ref_d, eq_q, cmp_q;
  logic [2:0]       trig_p;

  wire wr_cfg  = wr_en && (wr_addr == 2'd0);
  wire wr_ccr  = wr_en && (wr_addr == 2'd1);
  wire wr_out  = wr_en && (wr_addr == 2'd2);
  wire locked  = (lock_lvl == 2'd3) && (dir_r == 2'b00);

  wire eq      = (cnt == ccr_act);
  wire match   = eq & ~eq_q;
  wire cmp     = (cnt < ccr_act);
  wire is_pwm  = (mode_r == M_PWM1) || (mode_r == M_PWM2);
  wire pwm_lvl = (mode_r == M_PWM1) ? cmp : ~cmp;
  wire fire    = trig_p[1] & ~trig_p[2];
  wire clr_act = clre_r & clr_in;
  wire out_on  = en_r && (dir_r == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_r  <= '0;
      fast_r <= 1'b0;
      pre_r  <= 1'b0;
      mode_r <= '0;
      clre_r <= 1'b0;
    end else if (wr_cfg) begin
      fast_r <= wr_data[2];
      clre_r <= wr_data[8];
      if (!locked) begin
        pre_r  <= wr_data[3];
        mode_r <= wr_data[7:4];
      end
      if (!en_r) dir_r <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r   <= 1'b0;
      polm_r <= 1'b0;
      poln_r <= 1'b0;
    end else if (wr_out) begin
      en_r   <= wr_data[0];
      polm_r <= wr_data[1];
      poln_r <= wr_data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_sh  <= '0;
      ccr_act <= '0;
    end else begin
      if (wr_ccr) ccr_sh <= wr_data[CNT_W-1:0];
      if (wr_ccr && !pre_r) ccr_act <= wr_data[CNT_W-1:0];
      else if (upd && pre_r) ccr_act <= ccr_sh;
    end
  end

  always_comb begin
    ref_d = ref_q;
    case (mode_r)
      M_SET:  if (match) ref_d = 1'b1;
      M_CLR:  if (match) ref_d = 1'b0;
      M_TGL:  if (match) ref_d = ~ref_q;
      M_LOW:  ref_d = 1'b0;
      M_HIGH: ref_d = 1'b1;
      M_PWM1, M_PWM2:
        if ((mode_r != mode_q) || (cmp != cmp_q)) ref_d = pwm_lvl;
      default: ref_d = ref_q;
    endcase
    if (is_pwm && fast_r && fire) ref_d = (mode_r == M_PWM2);
    if (clr_act) ref_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      eq_q   <= 1'b0;
      cmp_q  <= 1'b0;
      mode_q <= '0;
      trig_p <= '0;
    end else begin
      ref_q  <= ref_d;
      eq_q   <= eq;
      cmp_q  <= cmp;
      mode_q <= mode_r;
      trig_p <= {trig_p[1:0], trig};
    end
  end

  assign oc_ref = ref_q & ~clr_act;
  assign oc_out = out_on ? (oc_ref ^ polm_r) : polm_r;
  assign oc_n   = out_on ? (~oc_ref ^ poln_r) : poln_r;

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(mode_r) && $stable(pre_r)));

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_r |=> $stable(dir_r));

  // R7
  ccr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !wr_ccr) |=> $stable(ccr_act));

  // R7
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre_r) |=> (ccr_act == $past(ccr_sh)));

  // R8
  clear_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !ref_q);

  // R5
  toggle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == M_TGL && match && !clr_act) |=> (ref_q != $past(ref_q)));

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == M_HIGH && !clr_act) |=> ref_q);

endmodule

// File: tb/tim_oc_channel_tb.sv
module tim_oc_channel_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] cnt = 0;
  logic upd = 0, trig = 0, clr_in = 0, wr_en = 0;
  logic [1:0] lock_lvl = 0, wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic oc_ref, oc_out, oc_n;
  int n_chk = 0, n_bad = 0;
  logic ex;

  tim_oc_channel #(.CNT_W(4), .DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .upd(upd), .trig(trig), .clr_in(clr_in),
    .lock_lvl(lock_lvl), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oc_ref(oc_ref), .oc_out(oc_out), .oc_n(oc_n));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input int c);
    cnt = 4'(c);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ref", oc_ref, 0); chk("R1 out", oc_out, 0); chk("R1 n", oc_n, 0);
    wr(2, 16'h1);
    chk("R2 enable n", oc_n, 1); chk("R2 enable out", oc_out, 0);

    wr(0, 16'h60);
    for (int p = 0; p < 16; p++) begin
      wr(1, 16'(p));
      for (int c = 0; c < 16; c++) begin
        step(c); chk("R3 pwm1", oc_ref, c < p);
        chk("R12 out", oc_out, c < p); chk("R12 n", oc_n, !(c < p));
      end
    end
    wr(0, 16'h70);
    for (int p = 0; p < 16; p++) begin
      wr(1, 16'(p));
      for (int c = 0; c < 16; c++) begin step(c); chk("R3 pwm2", oc_ref, c >= p); end
    end

    wr(1, 8); wr(0, 16'h160);
    step(2); chk("R4 pre", oc_ref, 1);
    clr_in = 1; #1 chk("R8 comb clear", oc_ref, 0);
    step(3); chk("R8 clear", oc_ref, 0);
    clr_in = 0;
    for (int c = 4; c < 9; c++) begin step(c); chk("R4 hold after clear", oc_ref, 0); end
    step(0); chk("R4 reload on change", oc_ref, 1);
    wr(0, 16'h50); step(0); chk("R6 force high", oc_ref, 1);
    clr_in = 1; #1 chk("R8 ignored comb", oc_ref, 1);
    step(0); chk("R8 ignored", oc_ref, 1);
    clr_in = 0;
    wr(0, 16'h00); step(9); chk("R6 frozen", oc_ref, 1);
    wr(0, 16'h60); step(9); chk("R4 frozen to pwm", oc_ref, 0);

    wr(1, 7); wr(0, 16'h40); step(0); chk("R6 force low", oc_ref, 0);
    wr(0, 16'h10);
    for (int c = 0; c < 16; c++) begin step(c); chk("R5 set", oc_ref, c >= 7); end
    wr(0, 16'h50); step(0);
    wr(0, 16'h20);
    for (int c = 0; c < 16; c++) begin step(c); chk("R5 clr", oc_ref, c < 7); end
    wr(0, 16'h40); step(0);
    wr(0, 16'h30);
    ex = 0;
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 16; c++) begin
        step(c); if (c == 7) ex = ~ex; chk("R5 toggle", oc_ref, ex);
      end
    step(7); ex = ~ex; chk("R5 toggle enter", oc_ref, ex);
    for (int k = 0; k < 3; k++) begin step(7); chk("R5 toggle once", oc_ref, ex); end

    wr(0, 16'h50); step(0); chk("R6 force high", oc_ref, 1);
    wr(0, 16'h00);
    for (int c = 0; c < 16; c++) begin step(c); chk("R6 frozen", oc_ref, 1); end
    wr(0, 16'h40); step(0); chk("R6 force low", oc_ref, 0);
    for (int m = 8; m < 16; m++) begin
      wr(0, 16'(m << 4));
      for (int c = 0; c < 16; c++) begin step(c); chk("R6 reserved", oc_ref, 0); end
    end
    wr(0, 16'h50); step(0); wr(0, 16'hF0);
    for (int c = 0; c < 16; c++) begin step(c); chk("R6 reserved hi", oc_ref, 1); end

    wr(0, 16'h60); wr(1, 10);
    for (int c = 0; c < 16; c++) begin step(c); chk("R7 immediate", oc_ref, c < 10); end
    wr(0, 16'h68); wr(1, 3);
    for (int c = 0; c < 16; c++) begin step(c); chk("R7 shadowed", oc_ref, c < 10); end
    upd = 1; @(negedge clk); upd = 0;
    for (int c = 0; c < 16; c++) begin step(c); chk("R7 loaded", oc_ref, c < 3); end
    wr(0, 16'h60); wr(1, 12);
    for (int c = 0; c < 16; c++) begin step(c); chk("R7 off again", oc_ref, c < 12); end

    wr(0, 16'h74); step(3); chk("R9 pwm2 base", oc_ref, 0);
    trig = 1;
    step(3); chk("R9 edge1", oc_ref, 0);
    step(3); chk("R9 edge2", oc_ref, 0);
    step(3); chk("R9 edge3", oc_ref, 1);
    step(3); chk("R9 held", oc_ref, 1);
    trig = 0;
    for (int k = 0; k < 3; k++) begin step(3); chk("R9 held low trig", oc_ref, 1); end
    wr(0, 16'h64); step(3); chk("R9 pwm1 base", oc_ref, 1);
    trig = 1;
    step(3); chk("R9 p1 edge1", oc_ref, 1);
    step(3); chk("R9 p1 edge2", oc_ref, 1);
    step(3); chk("R9 p1 edge3", oc_ref, 0);
    trig = 0;
    for (int k = 0; k < 3; k++) step(3);
    wr(0, 16'h70); step(3); chk("R9 no fast base", oc_ref, 0);
    trig = 1;
    for (int k = 0; k < 5; k++) begin step(3); chk("R9 no fast", oc_ref, 0); end
    trig = 0;
    for (int k = 0; k < 3; k++) step(3);
    wr(0, 16'h40); step(3); wr(0, 16'h14);
    trig = 1;
    for (int k = 0; k < 5; k++) begin step(3); chk("R9 non-pwm", oc_ref, 0); end
    trig = 0;
    for (int k = 0; k < 3; k++) step(3);

    wr(0, 16'h60); wr(1, 12); step(3); chk("R11 base", oc_ref, 1);
    lock_lvl = 3;
    wr(0, 16'h68); wr(1, 2);
    step(3); chk("R11 preload locked", oc_ref, 0);
    wr(0, 16'h50); step(3); chk("R11 mode locked", oc_ref, 0);
    lock_lvl = 2;
    wr(0, 16'h50); step(3); chk("R11 level2 open", oc_ref, 1);
    lock_lvl = 0;
    wr(2, 0); wr(0, 16'h41); step(3); chk("R11 input base", oc_ref, 0);
    lock_lvl = 3;
    wr(0, 16'h51); step(3); chk("R11 input unlocked", oc_ref, 1);
    lock_lvl = 0;
    wr(0, 16'h50);

    wr(2, 1); step(3); chk("R10 active", oc_out, 1);
    wr(0, 16'h51); step(3); chk("R10 dir locked", oc_out, 1);
    wr(2, 0); chk("R10 disabled", oc_out, 0);
    wr(0, 16'h51); wr(2, 1); step(3);
    chk("R10 input out", oc_out, 0); chk("R10 input n", oc_n, 0);
    wr(2, 0); wr(0, 16'h50); wr(2, 1); step(3); chk("R10 back", oc_out, 1);

    wr(2, 16'h7); step(3);
    chk("R12 pol out", oc_out, 0); chk("R12 pol n", oc_n, 1);
    wr(0, 16'h40); step(3);
    chk("R12 pol out lo", oc_out, 1); chk("R12 pol n lo", oc_n, 0);
    wr(2, 16'h6);
    chk("R12 idle out", oc_out, 1); chk("R12 idle n", oc_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule